// File: doc/BRIEF.md
# Watermark FIFO with DMA requests

The block is a 32-word, 16-bit circular FIFO sitting between a register-side data port and a card-side transfer engine. The direction input picks which side fills it and which side drains it. In receive, the transfer engine pushes card data and the host reads it. In transmit, the host writes and the transfer engine pops.

The fill count is compared with two programmable levels. In receive, the condition is a count above the upper level. In transmit, it is a count below the lower level. A per-direction DMA enable steers a true condition either to that direction's DMA request line or to that direction's status flag, never to both. When no transfer is active and the FIFO is empty, all four indications stay low. All indications are decoded from registered state, so a change takes effect in the cycle after the push, pop or configuration write that causes it.

Top module: `wm_fifo`

## Requirements
- R1: After reset the fill level is 0, the configuration readback is 0x1F00 (upper level 31, lower level 0, both DMA enables off), and both request lines and both flags are low.
- R2: Words leave the FIFO in the order they entered, including when the storage pointers wrap past entry 31 back to entry 0.
- R3: A push while the fill level is 32 is dropped: the level stays 32 and the stored words are unchanged.
- R4: A pop while the FIFO is empty leaves the fill level at 0 and leaves `head_data` unchanged.
- R5: With `dir_rx`=1, the receive DMA enable set and the fill level above the upper level, `rx_dma_req` is high and `rx_level_flag` is low.
- R6: With `dir_rx`=1, the receive DMA enable clear and the fill level above the upper level, `rx_level_flag` is high and `rx_dma_req` is low.
- R7: With `dir_rx`=0 and the fill level below the lower level, `tx_dma_req` is high if the transmit DMA enable is set; otherwise `tx_level_flag` is high.
- R8: While `xfer_active` is low and the fill level is 0, all four indications are low.
- R9: A configuration write that sets a direction's DMA enable clears that direction's flag in the next cycle.
- R10: With `dir_rx`=1, host writes and transfer pops are ignored. With `dir_rx`=0, transfer pushes and host reads are ignored.
- R11: A request line falls in the cycle after the push or pop that ends its condition.
- R12: `cfg_wdata` bit 15 is the receive DMA enable, bits 12:8 the upper level, bit 7 the transmit DMA enable and bits 4:0 the lower level. `cfg_rdata` returns these fields in the same positions, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | 1 = receive (transfer fills, host drains), 0 = transmit |
| xfer_active | input | 1 | A data transfer is in progress |
| host_wr_en | input | 1 | Host word write (transmit only) |
| host_wdata | input | 16 | Host write data |
| host_rd_en | input | 1 | Host word read (receive only) |
| xfer_push | input | 1 | Transfer-side push (receive only) |
| xfer_wdata | input | 16 | Transfer-side push data |
| xfer_pop | input | 1 | Transfer-side pop (transmit only) |
| head_data | output | 16 | Word at the read pointer |
| fill_level | output | 6 | Number of stored words |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| cfg_rdata | output | 16 | Configuration readback |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_level_flag | output | 1 | Receive level status flag |
| tx_level_flag | output | 1 | Transmit level status flag |

## Verification
The assertions assume that `dir_rx` changes only while no push or pop is driven. They also assume that push and pop on an empty FIFO are never driven in the same cycle. The stimulus sets the direction between operations and performs at most one push or pop per cycle. The bench's ignored-operation tests drive only the strobe of the inactive side.

// File: rtl/wm_fifo_pkg.sv
package wm_fifo_pkg;
  // Level fields are 5 bits wide; the FIFO depth must not exceed 32.
  localparam int LVL_W = 5;

  typedef struct packed {
    logic             rx_dma;
    logic [LVL_W-1:0] hi_lvl;
    logic             tx_dma;
    logic [LVL_W-1:0] lo_lvl;
  } wm_cfg_t;

  function automatic wm_cfg_t cfg_unpack(input logic [15:0] w);
    wm_cfg_t c;
    c.rx_dma = w[15];
    c.hi_lvl = w[12:8];
    c.tx_dma = w[7];
    c.lo_lvl = w[4:0];
    return c;
  endfunction

  function automatic logic [15:0] cfg_pack(input wm_cfg_t c);
    return {c.rx_dma, 2'b00, c.hi_lvl, c.tx_dma, 2'b00, c.lo_lvl};
  endfunction
endpackage

// File: rtl/wm_fifo_store.sv
module wm_fifo_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_nxt, wr_ptr;
  logic [CNT_W-1:0]  count_nxt;
  logic              push_ok, pop_ok;

  assign push_ok = push && (count != CNT_W'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign wr_ptr  = rd_ptr + count[PTR_W-1:0];
  assign head    = mem[rd_ptr];

  always_comb begin
    rd_ptr_nxt = rd_ptr;
    count_nxt  = count;
    if (pop_ok) rd_ptr_nxt = rd_ptr + PTR_W'(1);
    case ({push_ok, pop_ok})
      2'b10:   count_nxt = count + CNT_W'(1);
      2'b01:   count_nxt = count - CNT_W'(1);
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      count  <= '0;
    end else if (push_ok || pop_ok) begin
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/wm_fifo_cfg.sv
module wm_fifo_cfg
  import wm_fifo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output wm_cfg_t     cfg
);
  wm_cfg_t cfg_nxt;
  logic    unused_bits;

  assign unused_bits = ^{wdata[14:13], wdata[6:5]};

  always_comb begin
    cfg_nxt = cfg_unpack(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.rx_dma <= 1'b0;
      cfg.hi_lvl <= '1;
      cfg.tx_dma <= 1'b0;
      cfg.lo_lvl <= '0;
    end else if (wr_en) begin
      cfg <= cfg_nxt;
    end
  end
endmodule

// File: rtl/wm_fifo_level.sv
module wm_fifo_level
  import wm_fifo_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] count,
  input  logic             dir_rx,
  input  logic             active,
  input  wm_cfg_t          cfg,
  output logic             rx_req,
  output logic             tx_req,
  output logic             rx_flag,
  output logic             tx_flag
);
  logic live, rx_hit, tx_hit;

  always_comb begin
    live    = active || (count != '0);
    rx_hit  = live && dir_rx && (count > CNT_W'(cfg.hi_lvl));
    tx_hit  = live && !dir_rx && (count < CNT_W'(cfg.lo_lvl));
    rx_req  = rx_hit && cfg.rx_dma;
    rx_flag = rx_hit && !cfg.rx_dma;
    tx_req  = tx_hit && cfg.tx_dma;
    tx_flag = tx_hit && !cfg.tx_dma;
  end
endmodule

// File: rtl/wm_fifo.sv
module wm_fifo
  import wm_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_rx,
  input  logic              xfer_active,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd_en,
  input  logic              xfer_push,
  input  logic [DATA_W-1:0] xfer_wdata,
  input  logic              xfer_pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  fill_level,
  input  logic              cfg_wr_en,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic              rx_level_flag,
  output logic              tx_level_flag
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              push, pop;
  logic [DATA_W-1:0] push_data;
  wm_cfg_t           cfg;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Direction steers which side may push and which may pop.
  assign push      = dir_rx ? xfer_push : host_wr_en;
  assign pop       = dir_rx ? host_rd_en : xfer_pop;
  assign push_data = dir_rx ? xfer_wdata : host_wdata;

  wm_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (push),
    .pop   (pop),
    .wdata (push_data),
    .head  (head_data),
    .count (fill_level)
  );

  wm_fifo_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (cfg_wr_en),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );
  assign cfg_rdata = cfg_pack(cfg);

  wm_fifo_level #(.CNT_W(CNT_W)) u_level (
    .count   (fill_level),
    .dir_rx  (dir_rx),
    .active  (xfer_active),
    .cfg     (cfg),
    .rx_req  (rx_dma_req),
    .tx_req  (tx_dma_req),
    .rx_flag (rx_level_flag),
    .tx_flag (tx_level_flag)
  );
endmodule

// File: rtl/wm_fifo_chk.sv
module wm_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_rx,
  input logic              xfer_active,
  input logic              host_wr_en,
  input logic              xfer_push,
  input logic [DATA_W-1:0] head_data,
  input logic [CNT_W-1:0]  fill_level,
  input logic [15:0]       cfg_rdata,
  input logic              rx_dma_req,
  input logic              tx_dma_req,
  input logic              rx_level_flag,
  input logic              tx_level_flag
);
  logic any_push;
  assign any_push = dir_rx ? xfer_push : host_wr_en;

  // R3: the level never exceeds the depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(DEPTH));

  // R2: the level moves by at most one per cycle
  a_r2_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == $past(fill_level)) ||
    (fill_level == $past(fill_level) + CNT_W'(1)) ||
    (fill_level + CNT_W'(1) == $past(fill_level)));

  // R4: without a push, an empty FIFO stays empty with a stable head word
  a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0 && !any_push) |=> (fill_level == '0 && $stable(head_data)));

  // R5: receive request only in receive direction above the upper level
  a_r5_rx_req_cond: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> (dir_rx && fill_level > CNT_W'(cfg_rdata[12:8]) && cfg_rdata[15]));

  // R7: transmit indication only in transmit direction below the lower level
  a_r7_tx_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dma_req || tx_level_flag) |-> (!dir_rx && fill_level < CNT_W'(cfg_rdata[4:0])));

  // R6: at most one of the four indications is high
  a_r6_one_indication: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_dma_req, rx_level_flag, tx_dma_req, tx_level_flag}));

  // R8: idle and empty keeps everything low
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && fill_level == '0) |->
      !(rx_dma_req || rx_level_flag || tx_dma_req || tx_level_flag));
endmodule

bind wm_fifo wm_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_wm_fifo.sv
module tb_wm_fifo;
  localparam int DW = 16;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic dir_rx, xfer_active;
  logic host_wr_en, host_rd_en, xfer_push, xfer_pop, cfg_wr_en;
  logic [DW-1:0] host_wdata, xfer_wdata, head_data;
  logic [5:0] fill_level;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic rx_dma_req, tx_dma_req, rx_level_flag, tx_level_flag;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] q[$];

  always #2 clk = ~clk;

  wm_fifo dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares every accepted pop against the scoreboard (R2)
  always @(negedge clk) begin
    if (rst_n && ((dir_rx && host_rd_en) || (!dir_rx && xfer_pop)) && q.size() > 0)
      chk("R2 pop order", int'(head_data), int'(q.pop_front()));
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic host_wr(input logic [DW-1:0] d);
    host_wr_en = 1'b1; host_wdata = d;
    if (!dir_rx && q.size() < DEPTH) q.push_back(d);
    tick(); host_wr_en = 1'b0;
  endtask

  task automatic xfer_wr(input logic [DW-1:0] d);
    xfer_push = 1'b1; xfer_wdata = d;
    if (dir_rx && q.size() < DEPTH) q.push_back(d);
    tick(); xfer_push = 1'b0;
  endtask

  task automatic host_rd();
    host_rd_en = 1'b1; tick(); host_rd_en = 1'b0;
  endtask

  task automatic xfer_rd();
    xfer_pop = 1'b1; tick(); xfer_pop = 1'b0;
  endtask

  task automatic cfg_wr(input logic [15:0] w);
    cfg_wr_en = 1'b1; cfg_wdata = w; tick(); cfg_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; dir_rx = 1'b0; xfer_active = 1'b0;
    host_wr_en = 1'b0; host_rd_en = 1'b0; xfer_push = 1'b0; xfer_pop = 1'b0;
    cfg_wr_en = 1'b0; host_wdata = '0; xfer_wdata = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk("R1 level", fill_level, 0);
    chk("R1 cfg", cfg_rdata, 16'h1F00);
    chk("R1 outputs", {rx_dma_req, tx_dma_req, rx_level_flag, tx_level_flag}, 0);

    // R12 field packing
    cfg_wr(16'hFFFF);
    chk("R12 readback", cfg_rdata, 16'h9F9F);

    // R8 idle and empty: ae=4, no DMA, transmit
    dir_rx = 1'b0;
    cfg_wr(16'h1F04);
    chk("R8 idle quiet", {rx_dma_req, tx_dma_req, rx_level_flag, tx_level_flag}, 0);
    xfer_active = 1'b1; tick();
    chk("R7 tx flag", tx_level_flag, 1);
    chk("R7 tx req low", tx_dma_req, 0);

    // R9 enabling transmit DMA clears the flag next cycle
    cfg_wr(16'h1F84);
    chk("R9 tx flag cleared", tx_level_flag, 0);
    chk("R7 tx req", tx_dma_req, 1);

    // R11 request falls after the push that reaches the lower level
    host_wr(16'hA001); host_wr(16'hA002); host_wr(16'hA003);
    chk("R11 req still high", tx_dma_req, 1);
    host_wr(16'hA004);
    chk("R11 req fell", tx_dma_req, 0);
    chk("R11 level", fill_level, 4);

    // R10 transmit: transfer push and host read ignored
    xfer_wr(16'hDEAD);
    chk("R10 tx push ignored", fill_level, 4);
    host_rd();
    chk("R10 tx read ignored", fill_level, 4);
    chk("R10 head kept", head_data, 16'hA001);
    repeat (4) xfer_rd();
    chk("R2 drained", fill_level, 0);

    // R3 full and wrap
    for (int i = 0; i < DEPTH; i++) host_wr(16'h0100 + DW'(i));
    chk("R3 full level", fill_level, 32);
    host_wr(16'hBEEF);
    chk("R3 dropped push", fill_level, 32);
    chk("R3 head intact", head_data, 16'h0100);
    repeat (DEPTH) xfer_rd();
    chk("R2 empty after wrap", fill_level, 0);
    for (int i = 0; i < 40; i++) begin
      host_wr(16'h2000 + DW'(i));
      xfer_rd();
    end
    chk("R2 stream level", fill_level, 0);

    // R4 empty pop in receive direction
    dir_rx = 1'b1; tick();
    begin
      logic [DW-1:0] h;
      h = head_data;
      host_rd();
      chk("R4 level", fill_level, 0);
      chk("R4 head", head_data, int'(h));
    end

    // R6 receive flag without DMA: upper level 2
    cfg_wr(16'h0200);
    xfer_wr(16'hC001); xfer_wr(16'hC002);
    chk("R6 at level no flag", rx_level_flag, 0);
    xfer_wr(16'hC003);
    chk("R6 rx flag", rx_level_flag, 1);
    chk("R6 rx req low", rx_dma_req, 0);

    // R9 and R5 receive DMA
    cfg_wr(16'h8200);
    chk("R9 rx flag cleared", rx_level_flag, 0);
    chk("R5 rx req", rx_dma_req, 1);

    // R10 receive: host write and transfer pop ignored
    host_wr(16'hDEAD);
    chk("R10 rx write ignored", fill_level, 3);
    xfer_rd();
    chk("R10 rx pop ignored", fill_level, 3);

    // R11 request falls after host read
    host_rd();
    chk("R11 rx req fell", rx_dma_req, 0);
    host_rd(); host_rd();
    chk("R2 rx drained", fill_level, 0);
    chk("R2 queue empty", q.size(), 0);

    finish_run();
  end
endmodule